// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause-22 management transactions toward an external PHY over a two-wire MDC/MDIO link. Software writes a single 32-bit command word whose bits are laid out exactly like the serial management frame: start pattern, opcode, PHY address, register number, turnaround and a 16-bit data field. The controller sends 32 preamble ones and then shifts that word out on MDIO, most significant bit first. It derives MDC from the system clock by an even division ratio.

For a read opcode the controller stops driving MDIO from the second turnaround bit onward. It samples the 16 data bits on rising MDC edges and writes them into the low half of the command register, leaving the upper half as software wrote it. When a transaction finishes, a completion flag in bit 12 of the status word is set. Software clears it by writing a 1 to that bit. A command written while a transaction is still running is dropped.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, MDC is low, MDIO is not driven (output enable 0), the status word reads 0 and the command register reads 0.
- R2: A command write while idle starts a transaction. It sends 32 ones and then command bits 31 down to 0, one bit per MDC period.
- R3: MDC has a period of DIV system clocks and first rises DIV/2 clocks after the command write. MDIO and its enable change only together with a falling MDC edge.
- R4: An opcode field (bits 29:28) equal to 2'b10 marks a read. MDIO is released from frame bit 16, which is the 48th bit on the wire, through the last data bit.
- R5: For any other opcode the controller drives all 64 bits.
- R6: Status bit 12 becomes 1 exactly 64*DIV clocks after the accepted command write, on the final falling MDC edge. MDC then stays low and MDIO is released.
- R7: Writing the status word with bit 12 set clears the flag. Writing it with bit 12 clear leaves the flag unchanged. All other status bits read 0.
- R8: A command write during a transaction is ignored. The frame on the wire and the command register are unaffected.
- R9: After a read, command bits 15:0 hold the 16 bits sampled on rising MDC edges, first bit in bit 15, and bits 31:16 keep their written value. After any other opcode the register reads back the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 32 | Command word (frame image) |
| stat_we_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 32 | Status write data; bit 12 set clears completion |
| cmd_rdata_o | output | 32 | Command register contents |
| stat_rdata_o | output | 32 | Status word, completion in bit 12 |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
The completion flag is due exactly 64*DIV clocks after the edge that accepts a command, and the first rising MDC edge is due DIV/2 clocks after that edge. The bench counts clocks from the write edge and compares the counts to those values. Outputs are sampled on falling system-clock edges. The PHY model captures each wire bit and the enable at the sample where MDC is seen to rise, and it drives read data only after it sees MDC fall. Any MDIO change seen at a sample without a falling MDC edge is counted as a violation of R3.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int TOTAL_BITS = PRE_BITS + FRAME_BITS;
  localparam int DATA_BITS  = 16;
  localparam int DONE_BIT   = 12;
  // wire index of second turnaround bit (frame bit 16)
  localparam int RELEASE_IDX = TOTAL_BITS - DATA_BITS - 1;
  localparam int FIRST_DATA_IDX = TOTAL_BITS - DATA_BITS;
  localparam logic [1:0] OP_READ = 2'b10;

  function automatic logic is_read(input logic [FRAME_BITS-1:0] w);
    return w[29:28] == OP_READ;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r3_mdc_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_q);
  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  mdio_i,
  output logic                  busy_o,
  output logic                  fin_o,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  output logic [DATA_BITS-1:0]  rd_data_o
);
  localparam int IW = $clog2(TOTAL_BITS);

  logic                 busy_q;
  logic [IW-1:0]        idx_q;
  logic [DATA_BITS-1:0] rd_q;
  logic                 rd_mode;
  logic                 in_pre;
  logic [4:0]           fbit;

  assign rd_mode = is_read(frame_i);
  assign in_pre  = idx_q < IW'(PRE_BITS);
  assign fbit    = ~idx_q[4:0];
  assign fin_o   = busy_q && fall_i && (idx_q == IW'(TOTAL_BITS - 1));

  always_comb begin
    if (!busy_q || in_pre) mdio_o = 1'b1;
    else                   mdio_o = frame_i[fbit];
  end

  assign mdio_oe_o = busy_q && !(rd_mode && idx_q >= IW'(RELEASE_IDX));
  assign busy_o    = busy_q;
  assign rd_data_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      rd_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else begin
      if (rise_i && rd_mode && idx_q >= IW'(FIRST_DATA_IDX))
        rd_q <= {rd_q[DATA_BITS-2:0], mdio_i};
      if (fall_i) begin
        if (fin_o) busy_q <= 1'b0;
        else       idx_q  <= idx_q + 1'b1;
      end
    end
  end

  a_r2_preamble_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && in_pre |-> mdio_o && mdio_oe_o);
  a_r3_change_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) && !$past(fall_i) |-> $stable(mdio_o) && $stable(mdio_oe_o));
  a_r6_ends_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_q && !mdio_oe_o);
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  input  logic        stat_we_i,
  input  logic [31:0] stat_wdata_i,
  output logic [31:0] cmd_rdata_o,
  output logic [31:0] stat_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [31:0]          cmd_q;
  logic                 done_q;
  logic                 busy, fin, rise, fall;
  logic [DATA_BITS-1:0] rd_data;
  logic                 stat_unused;

  assign stat_unused = ^{stat_wdata_i[31:DONE_BIT+1], stat_wdata_i[DONE_BIT-1:0]};

  mdio_clk_div #(.DIV(DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(busy),
    .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cmd_we_i), .frame_i(cmd_q),
    .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
    .busy_o(busy), .fin_o(fin), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
    .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (cmd_we_i && !busy) begin
      cmd_q <= cmd_wdata_i;
    end else if (fin && is_read(cmd_q)) begin
      cmd_q[DATA_BITS-1:0] <= rd_data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              done_q <= 1'b0;
    else if (fin)                             done_q <= 1'b1;
    else if (stat_we_i && stat_wdata_i[DONE_BIT]) done_q <= 1'b0;
  end

  assign cmd_rdata_o  = cmd_q;
  assign stat_rdata_o = 32'(done_q) << DONE_BIT;

  a_r8_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && cmd_we_i && !fin |=> $stable(cmd_q));
  a_r7_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i && stat_wdata_i[DONE_BIT] && !fin |=> !done_q);
  a_r6_done_on_fin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> done_q && !busy);
  a_r9_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> cmd_q[31:DATA_BITS] == $past(cmd_q[31:DATA_BITS]));
endmodule

// File: tb/mdio_ctrl_test.sv
`timescale 1ns/1ps
module mdio_ctrl_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0, stat_we = 1'b0;
  logic [31:0] cmd_wdata = '0, stat_wdata = '0;
  logic [31:0] cmd_rdata, stat_rdata;
  logic        mdc, mdio_in = 1'b1, mdio_out, mdio_oe;

  mdio_ctrl #(.DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .stat_we_i(stat_we), .stat_wdata_i(stat_wdata), .cmd_rdata_o(cmd_rdata),
    .stat_rdata_o(stat_rdata), .mdc_o(mdc), .mdio_i(mdio_in), .mdio_o(mdio_out),
    .mdio_oe_o(mdio_oe)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // PHY model / monitor
  logic        rb[64], ro[64];
  int          rc[64];
  int          nr = 0, glitch = 0, start_cyc = 0;
  bit          mon_on = 0;
  logic [15:0] phy_d = '0;
  logic        p_mdc = 0, p_o = 1, p_oe = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (mdc && !p_mdc && nr < 64) begin
        rb[nr] = mdio_out; ro[nr] = mdio_oe; rc[nr] = cyc; nr = nr + 1;
      end
      if (!mdc && p_mdc && nr >= 48 && nr < 64) mdio_in = phy_d[63-nr];
      if (cyc != start_cyc && (mdio_out !== p_o || mdio_oe !== p_oe) && !(p_mdc && !mdc))
        glitch = glitch + 1;
    end
    p_mdc = mdc; p_o = mdio_out; p_oe = mdio_oe;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [31:0] c, input int k);
    return (k < 32) ? 1'b1 : c[63-k];
  endfunction
  function automatic logic exp_oe(input logic [31:0] c, input int k);
    return !(c[29:28] == 2'b10 && k >= 47);
  endfunction
  function automatic logic [31:0] exp_rb(input logic [31:0] c, input logic [15:0] p);
    return (c[29:28] == 2'b10) ? {c[31:16], p} : c;
  endfunction

  task automatic run_txn(input logic [31:0] c, input logic [15:0] p, input bit ign, input logic [31:0] iw);
    int w, n, bad_b, bad_oe, bad_t;
    @(negedge clk);
    start_cyc = cyc + 1; nr = 0; glitch = 0; phy_d = p; mdio_in = 1'b1; mon_on = 1;
    cmd_we = 1; cmd_wdata = c;
    @(negedge clk);
    cmd_we = 0; w = cyc;
    if (ign) begin
      repeat (20*DIV) @(negedge clk);
      cmd_we = 1; cmd_wdata = iw;
      @(negedge clk);
      cmd_we = 0;
      chk("R8", "cmd during busy", cmd_rdata, c);
    end
    n = 0;
    while (!stat_rdata[12] && n < 200*DIV) begin @(negedge clk); n++; end
    mon_on = 0;
    chk("R6", "done latency", cyc - w, 64*DIV);
    chk("R2", "mdc rises", nr, 64);
    bad_b = 0; bad_oe = 0; bad_t = 0;
    for (int k = 0; k < 64 && k < nr; k++) begin
      if (ro[k] !== exp_oe(c, k)) bad_oe++;
      if (ro[k] && rb[k] !== exp_bit(c, k)) bad_b++;
      if (k == 0 && rc[k] - w != DIV/2) bad_t++;
      if (k > 0 && rc[k] - rc[k-1] != DIV) bad_t++;
    end
    chk((c[29:28] == 2'b10) ? "R4" : "R5", "oe pattern errors", bad_oe, 0);
    chk("R2", "wire bit errors", bad_b, 0);
    chk("R3", "mdc timing errors", bad_t, 0);
    chk("R3", "mdio change off falling edge", glitch, 0);
    chk("R9", "readback", cmd_rdata, exp_rb(c, p));
    chk("R6", "idle after done", {30'd0, mdc, mdio_oe}, 0);
    @(negedge clk);
    stat_we = 1; stat_wdata = ~(32'h1 << 12);
    @(negedge clk);
    stat_we = 0;
    chk("R7", "write 0 keeps flag", stat_rdata, 32'h1000);
    stat_we = 1; stat_wdata = 32'h1 << 12;
    @(negedge clk);
    stat_we = 0;
    chk("R7", "write 1 clears flag", stat_rdata, 0);
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
    return {2'b01, op, a, r, 2'b10, d};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset cmd", cmd_rdata, 0);
    chk("R1", "reset status", stat_rdata, 0);
    chk("R1", "reset pins", {30'd0, mdc, mdio_oe}, 0);
    run_txn(mk(2'b01, 5'h01, 5'h00, 16'hA55A), 16'h0, 0, 0);
    run_txn(mk(2'b10, 5'h1F, 5'h1F, 16'h0000), 16'hFFFF, 0, 0);
    run_txn(mk(2'b10, 5'h00, 5'h02, 16'hFFFF), 16'h0000, 0, 0);
    run_txn(32'hFFFF_FFFF, 16'h1234, 0, 0);
    run_txn(mk(2'b10, 5'h05, 5'h03, 16'h0), 16'hC3A5, 1, 32'h5002_1234);
    run_txn(mk(2'b01, 5'h12, 5'h09, 16'h8001), 16'h0, 1, 32'h0);
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 12; i++) begin
      logic [31:0] rv, rv2;
      rv = $urandom; rv2 = $urandom;
      run_txn(mk(rv[0] ? 2'b10 : 2'b01, rv[5:1], rv[10:6], rv[31:16]), rv2[15:0], 0, 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule